// File: doc/BRIEF.md
# Reset-time strap configuration latch

This block takes its configuration from the system address bus while the chip is held in hard reset. Each address line has a pull-up at the pad, so an undriven line reads as 1. A board pulls a line low with an external resistor to select the other value. On the first clock edge after the hard reset is released, the block decodes the bus into start-up values for several control fields. It then holds those values unchanged until the next hard reset.

The decoded values cover several areas. The first is byte order, followed by the CPU bus-hold flag and the choice of bus arbiter. The block also sets the chip-select-0 boot settings: wait count, valid bit, port size and memory type. It loads the network-interface mode, an 11-bit user identifier and seven network-interface control bits. Any field that the straps do not set stays at zero. This includes the bus-speed field, where 00 selects the quarter-speed bus clock. Lighter resets, such as the network-interface and software resets, never reach this block, so they never cause a new capture.

Top module: `strap_latch`

## Requirements
- R1: While `hard_rst_n` is low, every output is 0.
- R2: The straps are taken from `strap_bus` on the first rising clock edge at which `hard_rst_n` is high. From then on, every output holds its value until `hard_rst_n` goes low again, and later changes on `strap_bus` have no effect.
- R3: `endian_le` is the inverse of strap bit 27. A strap of 0 therefore gives little-endian (1), and a strap of 1 gives big-endian (0).
- R4: `bus_hold` is the inverse of strap bit 26. A strap of 0 disables the CPU, so `bus_hold` is 1.
- R5: `int_arb` equals strap bit 25. A value of 1 selects the internal arbiter and 0 selects an external one.
- R6: Strap bits 24:23 set chip select 0 as follows.
  - 00: `cs_valid[0]`=0, `cs0_psize`=00, `cs0_dram`=0.
  - 01: valid, `cs0_psize`=01 (32-bit), `cs0_dram`=0.
  - 10: valid, `cs0_psize`=01, `cs0_dram`=1.
  - 11: valid, `cs0_psize`=10 (16-bit), `cs0_dram`=0.
  - After a capture, `cs0_wait` is 4'hF for every code.
- R7: `cs_valid[NCS-1:1]` is always 0, so chip select 0 is the only one that can be valid.
- R8: `eni_mode` equals strap bits 22:20, and `user_id` equals strap bits 19:9.
- R9: The bits of `eni_ctl` map as follows.
  - [6] is the inverse of strap bit 7.
  - [5]=bit 6, [4]=bit 5, [3]=bit 4, [2]=bit 3, [1]=bit 1 and [0]=bit 0.
  - Strap bits 8 and 2 have no effect on any output.
- R10: `bus_speed` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Power-up or external reset, active low, asynchronous assert |
| strap_bus | input | 28 | System address lines, pulled up at the pads |
| endian_le | output | 1 | 1 = little-endian |
| bus_hold | output | 1 | 1 = CPU kept off the bus |
| int_arb | output | 1 | 1 = internal bus arbiter |
| bus_speed | output | 2 | Bus clock divider select, 00 = quarter speed |
| cs0_wait | output | 4 | Chip-select-0 wait count |
| cs0_psize | output | 2 | Chip-select-0 port size, 01 = 32-bit, 10 = 16-bit |
| cs0_dram | output | 1 | Chip-select-0 memory is DRAM |
| cs_valid | output | NCS | Valid bit for each chip select |
| eni_mode | output | 3 | Network-interface mode |
| user_id | output | 11 | User identification field |
| eni_ctl | output | 7 | Network-interface control bits |

## Verification
The outputs go to zero as soon as reset is asserted, because the reset is asynchronous. The decoded fields become valid one rising edge after `hard_rst_n` goes high, and they stay valid until the next reset. The bench drives all inputs 2 ns after a rising edge. A behavioural model samples the bus on the same rising edge as the design. Every field is compared on each falling edge, so each result is checked half a cycle after the edge that produced it. Each run changes the bus after the capture and follows with a new reset using a different strap. Together these checks cover holding, re-capture and the two ignored bits.

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           hard_rst_n,
  input  logic [27:0]    strap_bus,
  output logic           endian_le,
  output logic           bus_hold,
  output logic           int_arb,
  output logic [1:0]     bus_speed,
  output logic [3:0]     cs0_wait,
  output logic [1:0]     cs0_psize,
  output logic           cs0_dram,
  output logic [NCS-1:0] cs_valid,
  output logic [2:0]     eni_mode,
  output logic [10:0]    user_id,
  output logic [6:0]     eni_ctl
);
  localparam logic [3:0] CS0_MAX_WAIT = 4'hF;

  logic       armed_q;
  logic       cs0_v_q;
  logic       cs0_on;
  logic [1:0] psize_d;
  logic       dram_d;

  always_comb begin
    case (strap_bus[24:23])
      2'b01:   {cs0_on, psize_d, dram_d} = {1'b1, 2'b01, 1'b0};
      2'b10:   {cs0_on, psize_d, dram_d} = {1'b1, 2'b01, 1'b1};
      2'b11:   {cs0_on, psize_d, dram_d} = {1'b1, 2'b10, 1'b0};
      default: {cs0_on, psize_d, dram_d} = '0;
    endcase
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      armed_q   <= 1'b1;
      endian_le <= 1'b0;
      bus_hold  <= 1'b0;
      int_arb   <= 1'b0;
      cs0_wait  <= '0;
      cs0_psize <= '0;
      cs0_dram  <= 1'b0;
      cs0_v_q   <= 1'b0;
      eni_mode  <= '0;
      user_id   <= '0;
      eni_ctl   <= '0;
    end else if (armed_q) begin
      armed_q   <= 1'b0;
      endian_le <= ~strap_bus[27];
      bus_hold  <= ~strap_bus[26];
      int_arb   <= strap_bus[25];
      cs0_wait  <= CS0_MAX_WAIT;
      cs0_psize <= psize_d;
      cs0_dram  <= dram_d;
      cs0_v_q   <= cs0_on;
      eni_mode  <= strap_bus[22:20];
      user_id   <= strap_bus[19:9];
      eni_ctl   <= {~strap_bus[7], strap_bus[6:3], strap_bus[1:0]};
    end
  end

  assign bus_speed = 2'b00;
  assign cs_valid  = {{(NCS-1){1'b0}}, cs0_v_q};
endmodule

module strap_latch_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           hard_rst_n,
  input logic           endian_le,
  input logic           bus_hold,
  input logic           int_arb,
  input logic [3:0]     cs0_wait,
  input logic [1:0]     cs0_psize,
  input logic           cs0_dram,
  input logic [NCS-1:0] cs_valid,
  input logic [2:0]     eni_mode,
  input logic [10:0]    user_id,
  input logic [6:0]     eni_ctl
);
  logic seen_q;
  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n) seen_q <= 1'b0;
    else             seen_q <= 1'b1;

  logic [31:0] bundle;
  assign bundle = {endian_le, bus_hold, int_arb, cs0_wait, cs0_psize, cs0_dram,
                   cs_valid[0], eni_mode, user_id, eni_ctl};

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    !hard_rst_n |-> (bundle == '0 && cs_valid == '0));

  // R2
  hold_after_capture_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    seen_q |=> $stable(bundle));

  // R7
  cs_only0_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    cs_valid[NCS-1:1] == '0);

  // R6
  cs0_on_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    cs_valid[0] |-> (cs0_wait == 4'hF && cs0_psize != 2'b00));

  // R6
  cs0_off_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !cs_valid[0] |-> (cs0_psize == 2'b00 && !cs0_dram));
endmodule

bind strap_latch strap_latch_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .endian_le(endian_le), .bus_hold(bus_hold),
  .int_arb(int_arb), .cs0_wait(cs0_wait), .cs0_psize(cs0_psize), .cs0_dram(cs0_dram),
  .cs_valid(cs_valid), .eni_mode(eni_mode), .user_id(user_id), .eni_ctl(eni_ctl)
);

// File: tb/strap_latch_tb.sv
module strap_latch_tb;
  localparam int NCS = 4;

  logic           clk = 1'b0;
  logic           hard_rst_n = 1'b0;
  logic [27:0]    strap_bus = '1;
  logic           endian_le, bus_hold, int_arb, cs0_dram;
  logic [1:0]     bus_speed, cs0_psize;
  logic [3:0]     cs0_wait;
  logic [NCS-1:0] cs_valid;
  logic [2:0]     eni_mode;
  logic [10:0]    user_id;
  logic [6:0]     eni_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  strap_latch #(.NCS(NCS)) u_dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .strap_bus(strap_bus),
    .endian_le(endian_le), .bus_hold(bus_hold), .int_arb(int_arb),
    .bus_speed(bus_speed), .cs0_wait(cs0_wait), .cs0_psize(cs0_psize),
    .cs0_dram(cs0_dram), .cs_valid(cs_valid), .eni_mode(eni_mode),
    .user_id(user_id), .eni_ctl(eni_ctl)
  );

  // reference: remembers the bus seen at the first edge out of reset
  bit          have = 1'b0;
  logic [27:0] cap  = '0;
  always @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) have <= 1'b0;
    else if (!have) begin cap <= strap_bus; have <= 1'b1; end
  end

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int e_v, e_ps, e_dr;
    if (!have) begin
      chk("R1", "all", {endian_le, bus_hold, int_arb, cs0_wait, cs0_psize, cs0_dram,
                        eni_mode, user_id, eni_ctl, bus_speed}, 0);
      chk("R1", "cs_valid", cs_valid, 0);
    end else begin
      case (cap[24:23])
        2'b00: begin e_v = 0; e_ps = 0; e_dr = 0; end
        2'b01: begin e_v = 1; e_ps = 1; e_dr = 0; end
        2'b10: begin e_v = 1; e_ps = 1; e_dr = 1; end
        default: begin e_v = 1; e_ps = 2; e_dr = 0; end
      endcase
      chk("R3", "endian_le", endian_le, cap[27] ? 0 : 1);
      chk("R4", "bus_hold", bus_hold, cap[26] ? 0 : 1);
      chk("R5", "int_arb", int_arb, cap[25]);
      chk("R6", "cs0_wait", cs0_wait, 15);
      chk("R6", "cs0_psize", cs0_psize, e_ps);
      chk("R6", "cs0_dram", cs0_dram, e_dr);
      chk("R7", "cs_valid", cs_valid, e_v);
      chk("R8", "eni_mode", eni_mode, int'(cap[22:20]));
      chk("R8", "user_id", user_id, int'(cap[19:9]));
      chk("R9", "eni_ctl", eni_ctl,
          (cap[7] ? 0 : 64) + int'(cap[6:3]) * 4 + int'(cap[1:0]));
      chk("R10", "bus_speed", bus_speed, 0);
    end
  end

  // R2: reset with a strap, release, then disturb the bus
  task automatic boot(input logic [27:0] s);
    @(posedge clk); #2; hard_rst_n = 1'b0; strap_bus = s;
    repeat (3) @(posedge clk);
    #2; hard_rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2; strap_bus = ~s;
    repeat (3) @(posedge clk);
    #2; strap_bus = s ^ 28'h5A5_A5A5;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    boot('1);                 // undriven bus, all pull-ups
    boot('0);
    boot(28'h080_0000);       // cs0 code 01
    boot(28'h100_0000);       // cs0 code 10
    boot(28'h180_0000);       // cs0 code 11
    boot(28'hA5A_5A5A);
    boot(28'h5A5_A5A5);
    boot(28'h123_4567);       // R9: same as next except bits 8 and 2
    boot(28'h123_4563 ^ 28'h100);
    boot(28'h7FF_FE7B);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule